// File: doc/BRIEF.md
# Register Rename Map Table

This block is the register alias table at the rename stage of an out-of-order core. Architectural registers share one flat index space with three ranges. The lowest indices are integer registers. Floating-point registers come next. The highest indices are miscellaneous registers, which are never renamed. The table holds one physical register index for every integer and floating-point architectural register. Each of the two renamed classes has its own free pool of physical registers, and each pool is a FIFO queue.

The block accepts one operation of each kind per clock.

- **Rename port:** takes a destination register. It pops a fresh physical register from the matching pool, records it in the table, and returns both the fresh index and the mapping it replaced.
- **Lookup port:** resolves a source register without changing any state.
- **Force-write port:** overwrites one mapping during recovery.
- **Release port:** returns a retired physical register to the pool of its class.
- **Free-count output:** reports how many renames are still guaranteed, which is the smaller of the two pool occupancies.

Lookup and rename results are combinational from the state held before the clock edge. The table and the pools update at that edge. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `rename_map_table`

## Requirements
- R1: After reset, integer architectural register i maps to physical INT_BIND_BASE+i, and floating-point register NUM_INT_ARCH+j maps to FP_BIND_BASE+j. The free count then equals the smaller number of unbound physical registers in either class (8 with the defaults), and no stall is raised.
- R2: Renaming a non-zero integer register returns the head of the integer pool as the new index and the old table entry as the previous index. The new index is below NUM_INT_PHYS, and it is visible on the lookup port from the next cycle.
- R3: Renaming a non-zero floating-point register takes the head of the floating-point pool. The new index lies in [NUM_INT_PHYS, NUM_INT_PHYS+NUM_FP_PHYS).
- R4: Renaming either zero register (integer index INT_ZERO_IDX, flat floating-point index FP_ZERO_IDX) returns that architectural index as the new index and the current entry as the previous index. It consumes no pool entry, changes no mapping and never stalls.
- R5: For an index a at or above NUM_INT_ARCH+NUM_FP_ARCH, both rename and lookup return a-(NUM_INT_ARCH+NUM_FP_ARCH)+(NUM_INT_PHYS+NUM_FP_PHYS). On rename, the previous index equals that same value.
- R6: A lookup returns the current mapping and never alters the table or the pools.
- R7: A forced write replaces the entry of an integer or floating-point register from the next cycle, and it wins over a rename of the same entry in the same cycle. A forced write to a miscellaneous index changes no entry.
- R8: The free count is the minimum of the integer pool occupancy and the floating-point pool occupancy.
- R9: When the pool a rename needs is empty, the stall output is high in that cycle. The mapping and the free count then remain unchanged.
- R10: A release of an index below NUM_INT_PHYS goes to the integer pool, and any other index below the total physical count goes to the floating-point pool. Each pool hands out entries in FIFO order. Releases of miscellaneous indices, or of the physical registers bound to the zero registers at reset, are dropped.
- R11: Rename and lookup outputs reflect the state before the clock edge in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Architectural register to rename |
| ren_phys | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Physical register replaced by the rename |
| ren_stall | output | 1 | Rename refused, pool empty |
| lk_arch | input | AW | Architectural register to look up |
| lk_phys | output | PW | Current mapping of lk_arch |
| wr_valid | input | 1 | Forced mapping write |
| wr_arch | input | AW | Entry to overwrite |
| wr_phys | input | PW | Value to write |
| rel_valid | input | 1 | Release request |
| rel_phys | input | PW | Physical register being freed |
| free_count | output | CW | Renames still possible (min of both pools) |

## Verification
The bench drains the integer pool until a rename stalls. A design that pops anyway would hand out a stale or duplicated register and corrupt the mapping or the count. It releases an index into a pool that was already partly consumed and checks that the index reappears only after the older entries, which exposes a pool that behaves as a stack. The bench renames both zero registers and then looks them up, which catches a design that allocates for them or rewrites their entries. It also issues a forced write to a miscellaneous index whose low bits alias a real entry, and a forced write that collides with a rename of the same entry. A design that truncates the index or applies the writes in the wrong order would corrupt a mapping. After a fresh reset, consuming only floating-point registers checks that the free count tracks the smaller pool and not a fixed class.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_MISC = 2'd2
  } reg_cls_e;
endpackage

// File: rtl/rmt_arch_decode.sv
module rmt_arch_decode #(
  parameter int NI = 8,
  parameter int NF = 8,
  parameter int AW = 5,
  parameter int TW = 4
) (
  input  logic [AW-1:0]     arch,
  output rmt_pkg::reg_cls_e cls,
  output logic [TW-1:0]     tidx
);
  localparam logic [AW-1:0] LIM_I = AW'(NI);
  localparam logic [AW-1:0] LIM_R = AW'(NI + NF);

  always_comb begin
    if (arch < LIM_I)      cls = rmt_pkg::CLS_INT;
    else if (arch < LIM_R) cls = rmt_pkg::CLS_FP;
    else                   cls = rmt_pkg::CLS_MISC;
    tidx = (cls == rmt_pkg::CLS_MISC) ? '0 : arch[TW-1:0];
  end
endmodule

// File: rtl/rmt_free_fifo.sv
module rmt_free_fifo #(
  parameter int DEPTH  = 8,
  parameter int PW     = 6,
  parameter int CW     = 4,
  parameter int LO     = 0,
  parameter int ARCH_N = 8,
  parameter int BASE   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_data,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam int PTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OFF = BASE - LO;

  logic [PW-1:0]  mem_q [DEPTH];
  logic [PW-1:0]  mem_d [DEPTH];
  logic [PTW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  // k-th register of the class that is not bound at reset
  function automatic logic [PW-1:0] seed(input int k);
    return (k < OFF) ? PW'(LO + k) : PW'(LO + k + ARCH_N);
  endfunction

  function automatic logic [PTW-1:0] bump(input logic [PTW-1:0] p);
    return (p == PTW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    mem_d = mem_q;
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push) begin
      mem_d[wr_q] = push_data;
      wr_d        = bump(wr_q);
    end
    if (pop) rd_d = bump(rd_q);
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= seed(k);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (push) mem_q <= mem_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rmt_map_table.sv
module rmt_map_table #(
  parameter int NI       = 8,
  parameter int NF       = 8,
  parameter int PW       = 6,
  parameter int TW       = 4,
  parameter int INT_BASE = 0,
  parameter int FP_BASE  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] ra_idx,
  output logic [PW-1:0] ra_data,
  input  logic [TW-1:0] rb_idx,
  output logic [PW-1:0] rb_data,
  input  logic          wa_en,
  input  logic [TW-1:0] wa_idx,
  input  logic [PW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [TW-1:0] wb_idx,
  input  logic [PW-1:0] wb_data
);
  localparam int NR = NI + NF;

  logic [PW-1:0] map_q [NR];
  logic [PW-1:0] map_d [NR];
  logic          upd;

  always_comb begin
    map_d = map_q;
    if (wa_en) map_d[wa_idx] = wa_data;
    if (wb_en) map_d[wb_idx] = wb_data;  // recovery write has priority
    upd = wa_en | wb_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++)
        map_q[i] <= (i < NI) ? PW'(INT_BASE + i) : PW'(FP_BASE + i - NI);
    end else if (upd) begin
      map_q <= map_d;
    end
  end

  assign ra_data = map_q[ra_idx];
  assign rb_data = map_q[rb_idx];
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_INT_ARCH  = 8,
  parameter int NUM_FP_ARCH   = 8,
  parameter int NUM_MISC      = 4,
  parameter int NUM_INT_PHYS  = 16,
  parameter int NUM_FP_PHYS   = 16,
  parameter int INT_ZERO_IDX  = 0,
  parameter int FP_ZERO_IDX   = 8,
  parameter int INT_BIND_BASE = 0,
  parameter int FP_BIND_BASE  = 16,
  localparam int NR      = NUM_INT_ARCH + NUM_FP_ARCH,
  localparam int NP      = NUM_INT_PHYS + NUM_FP_PHYS,
  localparam int AW      = $clog2(NR + NUM_MISC),
  localparam int PW      = $clog2(NP + NUM_MISC),
  localparam int DEPTH_I = NUM_INT_PHYS - NUM_INT_ARCH,
  localparam int DEPTH_F = NUM_FP_PHYS - NUM_FP_ARCH,
  localparam int CW      = $clog2(((DEPTH_I > DEPTH_F) ? DEPTH_I : DEPTH_F) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic [PW-1:0] ren_phys,
  output logic [PW-1:0] ren_prev,
  output logic          ren_stall,
  input  logic [AW-1:0] lk_arch,
  output logic [PW-1:0] lk_phys,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_phys,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_phys,
  output logic [CW-1:0] free_count
);
  import rmt_pkg::*;

  localparam int TW = $clog2(NR);
  localparam logic [PW-1:0] PIN_I = PW'(INT_BIND_BASE + INT_ZERO_IDX);
  localparam logic [PW-1:0] PIN_F = PW'(FP_BIND_BASE + FP_ZERO_IDX - NUM_INT_ARCH);

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_cls_e      r_cls, l_cls, w_cls;
  logic [TW-1:0] r_tidx, l_tidx, w_tidx;

  rmt_arch_decode #(.NI(NUM_INT_ARCH), .NF(NUM_FP_ARCH), .AW(AW), .TW(TW))
    u_dec_ren (.arch(ren_arch), .cls(r_cls), .tidx(r_tidx));
  rmt_arch_decode #(.NI(NUM_INT_ARCH), .NF(NUM_FP_ARCH), .AW(AW), .TW(TW))
    u_dec_lk  (.arch(lk_arch),  .cls(l_cls), .tidx(l_tidx));
  rmt_arch_decode #(.NI(NUM_INT_ARCH), .NF(NUM_FP_ARCH), .AW(AW), .TW(TW))
    u_dec_wr  (.arch(wr_arch),  .cls(w_cls), .tidx(w_tidx));

  logic [PW-1:0] int_head, fp_head, tbl_ren, tbl_lk;
  logic [CW-1:0] int_cnt, fp_cnt;
  logic          int_empty, fp_empty, int_full, fp_full;
  logic          ren_zero, need_int, need_fp, pop_int, pop_fp;
  logic          rel_ok, rel_is_int, push_int, push_fp, force_en;
  logic [PW-1:0] ren_misc, lk_misc;

  // rename decision
  always_comb begin
    ren_zero  = (ren_arch == AW'(INT_ZERO_IDX)) || (ren_arch == AW'(FP_ZERO_IDX));
    need_int  = ren_valid && (r_cls == CLS_INT) && !ren_zero;
    need_fp   = ren_valid && (r_cls == CLS_FP)  && !ren_zero;
    ren_stall = (need_int && int_empty) || (need_fp && fp_empty);
    pop_int   = need_int && !int_empty;
    pop_fp    = need_fp  && !fp_empty;
    ren_misc  = PW'(ren_arch) + PW'(NP) - PW'(NR);
    lk_misc   = PW'(lk_arch)  + PW'(NP) - PW'(NR);
    force_en  = wr_valid && (w_cls != CLS_MISC);
  end

  // result muxes
  always_comb begin
    if (r_cls == CLS_MISC) begin
      ren_phys = ren_misc;
      ren_prev = ren_misc;
    end else begin
      ren_prev = tbl_ren;
      if (ren_zero)            ren_phys = PW'(ren_arch);
      else if (r_cls == CLS_INT) ren_phys = int_head;
      else                     ren_phys = fp_head;
    end
    lk_phys = (l_cls == CLS_MISC) ? lk_misc : tbl_lk;
  end

  // release steering
  always_comb begin
    rel_ok     = rel_valid && (rel_phys < PW'(NP)) &&
                 (rel_phys != PIN_I) && (rel_phys != PIN_F);
    rel_is_int = (rel_phys < PW'(NUM_INT_PHYS));
    push_int   = rel_ok &&  rel_is_int && !int_full;
    push_fp    = rel_ok && !rel_is_int && !fp_full;
  end

  rmt_map_table #(
    .NI(NUM_INT_ARCH), .NF(NUM_FP_ARCH), .PW(PW), .TW(TW),
    .INT_BASE(INT_BIND_BASE), .FP_BASE(FP_BIND_BASE)
  ) u_tbl (
    .clk(clk), .rst_n(rst_sync_n),
    .ra_idx(r_tidx), .ra_data(tbl_ren),
    .rb_idx(l_tidx), .rb_data(tbl_lk),
    .wa_en(pop_int | pop_fp), .wa_idx(r_tidx),
    .wa_data(pop_int ? int_head : fp_head),
    .wb_en(force_en), .wb_idx(w_tidx), .wb_data(wr_phys)
  );

  rmt_free_fifo #(
    .DEPTH(DEPTH_I), .PW(PW), .CW(CW), .LO(0),
    .ARCH_N(NUM_INT_ARCH), .BASE(INT_BIND_BASE)
  ) u_pool_int (
    .clk(clk), .rst_n(rst_sync_n), .pop(pop_int), .push(push_int),
    .push_data(rel_phys), .head(int_head), .count(int_cnt),
    .empty(int_empty), .full(int_full)
  );

  rmt_free_fifo #(
    .DEPTH(DEPTH_F), .PW(PW), .CW(CW), .LO(NUM_INT_PHYS),
    .ARCH_N(NUM_FP_ARCH), .BASE(FP_BIND_BASE)
  ) u_pool_fp (
    .clk(clk), .rst_n(rst_sync_n), .pop(pop_fp), .push(push_fp),
    .push_data(rel_phys), .head(fp_head), .count(fp_cnt),
    .empty(fp_empty), .full(fp_full)
  );

  assign free_count = (int_cnt < fp_cnt) ? int_cnt : fp_cnt;
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int NUM_INT_ARCH = 8,
  parameter int NUM_FP_ARCH  = 8,
  parameter int NUM_INT_PHYS = 16,
  parameter int NUM_FP_PHYS  = 16,
  parameter int INT_ZERO_IDX = 0,
  parameter int FP_ZERO_IDX  = 8,
  parameter int AW = 5,
  parameter int PW = 6,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ren_valid,
  input logic [AW-1:0] ren_arch,
  input logic [PW-1:0] ren_phys,
  input logic [PW-1:0] ren_prev,
  input logic          ren_stall,
  input logic [AW-1:0] lk_arch,
  input logic [PW-1:0] lk_phys,
  input logic          wr_valid,
  input logic          rel_valid,
  input logic [CW-1:0] free_count
);
  localparam logic [AW-1:0] A_NI  = AW'(NUM_INT_ARCH);
  localparam logic [AW-1:0] A_NR  = AW'(NUM_INT_ARCH + NUM_FP_ARCH);
  localparam logic [AW-1:0] A_IZ  = AW'(INT_ZERO_IDX);
  localparam logic [AW-1:0] A_FZ  = AW'(FP_ZERO_IDX);
  localparam logic [PW-1:0] P_NI  = PW'(NUM_INT_PHYS);
  localparam logic [PW-1:0] P_NP  = PW'(NUM_INT_PHYS + NUM_FP_PHYS);

  logic is_zero, grant_int, grant_fp;
  assign is_zero   = (ren_arch == A_IZ) || (ren_arch == A_FZ);
  assign grant_int = ren_valid && !ren_stall && !is_zero && (ren_arch < A_NI);
  assign grant_fp  = ren_valid && !ren_stall && !is_zero &&
                     (ren_arch >= A_NI) && (ren_arch < A_NR);

  p_int_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_int |-> (ren_phys < P_NI));

  p_map_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_int || grant_fp) && !wr_valid |=>
      (lk_arch != $past(ren_arch)) || (lk_phys == $past(ren_phys)));

  p_fp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fp |-> (ren_phys >= P_NI) && (ren_phys < P_NP));

  p_zero_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && is_zero |-> !ren_stall && (ren_phys == PW'(ren_arch)));

  p_misc_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && (ren_arch >= A_NR) |->
      (ren_prev == ren_phys) && (ren_phys >= P_NP) && !ren_stall);

  p_stall_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |-> (free_count == '0));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall && !rel_valid |=> $stable(free_count));
endmodule

bind rename_map_table rmt_checker #(
  .NUM_INT_ARCH(NUM_INT_ARCH), .NUM_FP_ARCH(NUM_FP_ARCH),
  .NUM_INT_PHYS(NUM_INT_PHYS), .NUM_FP_PHYS(NUM_FP_PHYS),
  .INT_ZERO_IDX(INT_ZERO_IDX), .FP_ZERO_IDX(FP_ZERO_IDX),
  .AW(AW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
  .ren_phys(ren_phys), .ren_prev(ren_prev), .ren_stall(ren_stall),
  .lk_arch(lk_arch), .lk_phys(lk_phys), .wr_valid(wr_valid),
  .rel_valid(rel_valid), .free_count(free_count)
);

// File: tb/sim_rename_map_table.sv
`timescale 1ns/1ps
module sim_rename_map_table;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ren_valid = 1'b0;
  logic [AW-1:0] ren_arch = '0;
  logic [PW-1:0] ren_phys, ren_prev;
  logic          ren_stall;
  logic [AW-1:0] lk_arch = '0;
  logic [PW-1:0] lk_phys;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_arch = '0;
  logic [PW-1:0] wr_phys = '0;
  logic          rel_valid = 1'b0;
  logic [PW-1:0] rel_phys = '0;
  logic [CW-1:0] free_count;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  rename_map_table u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_phys(ren_phys), .ren_prev(ren_prev), .ren_stall(ren_stall),
    .lk_arch(lk_arch), .lk_phys(lk_phys), .wr_valid(wr_valid),
    .wr_arch(wr_arch), .wr_phys(wr_phys), .rel_valid(rel_valid),
    .rel_phys(rel_phys), .free_count(free_count)
  );

  // op codes: 0 lookup, 1 rename, 2 forced write, 3 release
  // fields: op[32:31] arch[30:26] data[25:20] e_phys[19:14] e_prev[13:8] e_fc[7:4] req[3:0]
  localparam int NV = 25;
  localparam logic [32:0] VEC [NV] = '{
    {2'd0, 5'd3,  6'd0,  6'd3,  6'd0,  4'd8, 4'd1},   // R1 int reset binding
    {2'd0, 5'd12, 6'd0,  6'd20, 6'd0,  4'd8, 4'd1},   // R1 fp reset binding
    {2'd0, 5'd17, 6'd0,  6'd33, 6'd0,  4'd8, 4'd5},   // R5 misc lookup
    {2'd1, 5'd3,  6'd0,  6'd8,  6'd3,  4'd8, 4'd2},   // R2 first int rename
    {2'd1, 5'd3,  6'd0,  6'd9,  6'd8,  4'd7, 4'd2},   // R2 prev is last rename
    {2'd0, 5'd3,  6'd0,  6'd9,  6'd0,  4'd6, 4'd6},   // R6 R11 lookup current
    {2'd1, 5'd10, 6'd0,  6'd24, 6'd18, 4'd6, 4'd3},   // R3 fp rename
    {2'd1, 5'd0,  6'd0,  6'd0,  6'd0,  4'd6, 4'd4},   // R4 int zero
    {2'd1, 5'd8,  6'd0,  6'd8,  6'd16, 4'd6, 4'd4},   // R4 fp zero
    {2'd0, 5'd0,  6'd0,  6'd0,  6'd0,  4'd6, 4'd4},   // R4 entry unchanged
    {2'd0, 5'd8,  6'd0,  6'd16, 6'd0,  4'd6, 4'd4},   // R4 entry unchanged
    {2'd1, 5'd19, 6'd0,  6'd35, 6'd35, 4'd6, 4'd5},   // R5 misc rename
    {2'd2, 5'd5,  6'd30, 6'd0,  6'd0,  4'd6, 4'd7},   // R7 forced write
    {2'd0, 5'd5,  6'd0,  6'd30, 6'd0,  4'd6, 4'd7},   // R7 write visible
    {2'd2, 5'd18, 6'd40, 6'd0,  6'd0,  4'd6, 4'd7},   // R7 misc write
    {2'd0, 5'd2,  6'd0,  6'd2,  6'd0,  4'd6, 4'd7},   // R7 aliased entry kept
    {2'd3, 5'd0,  6'd3,  6'd0,  6'd0,  4'd6, 4'd10},  // R10 release int 3
    {2'd3, 5'd0,  6'd33, 6'd0,  6'd0,  4'd7, 4'd10},  // R10 misc release dropped
    {2'd3, 5'd0,  6'd0,  6'd0,  6'd0,  4'd7, 4'd10},  // R10 pinned int dropped
    {2'd3, 5'd0,  6'd16, 6'd0,  6'd0,  4'd7, 4'd10},  // R10 pinned fp dropped
    {2'd0, 5'd10, 6'd0,  6'd24, 6'd0,  4'd7, 4'd3},   // R3 mapping held
    {2'd3, 5'd0,  6'd20, 6'd0,  6'd0,  4'd7, 4'd10},  // R10 release fp 20
    {2'd0, 5'd18, 6'd0,  6'd34, 6'd0,  4'd7, 4'd5},   // R5 misc lookup
    {2'd1, 5'd4,  6'd0,  6'd10, 6'd4,  4'd7, 4'd2},   // R2 FIFO head
    {2'd0, 5'd11, 6'd0,  6'd19, 6'd0,  4'd6, 4'd8}    // R8 min follows int pool
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 1'b0; wr_valid = 1'b0; rel_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    do_reset();
    // reset state R1 R8
    chk(free_count == 4'd8, "R1 R8 reset free count", free_count, 8);
    chk(ren_stall == 1'b0, "R1 no stall at reset", ren_stall, 0);

    // vector walk; outputs checked before the edge (R11)
    for (int v = 0; v < NV; v++) begin
      logic [32:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[3:0], v);
      @(negedge clk);
      idle();
      case (e[32:31])
        2'd0: lk_arch = e[30:26];
        2'd1: begin ren_valid = 1'b1; ren_arch = e[30:26]; end
        2'd2: begin wr_valid = 1'b1; wr_arch = e[30:26]; wr_phys = e[25:20]; end
        default: begin rel_valid = 1'b1; rel_phys = e[25:20]; end
      endcase
      #5;
      chk(free_count == e[7:4], {tag, " free"}, free_count, int'(e[7:4]));
      if (e[32:31] == 2'd0)
        chk(lk_phys == e[19:14], {tag, " lookup"}, lk_phys, int'(e[19:14]));
      if (e[32:31] == 2'd1) begin
        chk(ren_stall == 1'b0, {tag, " stall"}, ren_stall, 0);
        chk(ren_phys == e[19:14], {tag, " new"}, ren_phys, int'(e[19:14]));
        chk(ren_prev == e[13:8], {tag, " prev"}, ren_prev, int'(e[13:8]));
      end
    end

    // R9 R10: drain the integer pool in FIFO order 11..15 then released 3
    for (int k = 0; k < 6; k++) begin
      int exp_p;
      exp_p = (k < 5) ? 11 + k : 3;
      @(negedge clk);
      idle(); ren_valid = 1'b1; ren_arch = 5'd1;
      #5;
      chk(free_count == CW'(6 - k), "R8 drain count", free_count, 6 - k);
      chk(ren_phys == PW'(exp_p) && !ren_stall, "R10 fifo order", ren_phys, exp_p);
    end
    @(negedge clk);
    idle(); ren_valid = 1'b1; ren_arch = 5'd1;
    #5;
    chk(ren_stall == 1'b1, "R9 stall on empty", ren_stall, 1);
    @(negedge clk);
    idle(); lk_arch = 5'd1;
    #5;
    chk(lk_phys == 6'd3, "R9 map unchanged", lk_phys, 3);
    chk(free_count == 4'd0, "R9 count unchanged", free_count, 0);

    // R10 release refills; next rename gets it
    @(negedge clk);
    idle(); rel_valid = 1'b1; rel_phys = 6'd8;
    @(negedge clk);
    idle(); ren_valid = 1'b1; ren_arch = 5'd1;
    #5;
    chk(free_count == 4'd1, "R10 release counted", free_count, 1);
    chk(ren_phys == 6'd8 && ren_prev == 6'd3 && !ren_stall, "R10 reuse", ren_phys, 8);

    // R7 forced write wins over a same-cycle rename of the same entry
    @(negedge clk);
    idle(); rel_valid = 1'b1; rel_phys = 6'd12;
    @(negedge clk);
    idle(); ren_valid = 1'b1; ren_arch = 5'd2;
    wr_valid = 1'b1; wr_arch = 5'd2; wr_phys = 6'd7;
    @(negedge clk);
    idle(); lk_arch = 5'd2;
    #5;
    chk(lk_phys == 6'd7, "R7 write priority", lk_phys, 7);
    chk(free_count == 4'd0, "R8 pool consumed", free_count, 0);

    // fresh reset: full R1 binding, then R8 with fp pool smaller
    do_reset();
    for (int a = 0; a < 16; a++) begin
      int exp_p;
      exp_p = (a < 8) ? a : 16 + a - 8;
      @(negedge clk);
      idle(); lk_arch = AW'(a);
      #5;
      chk(lk_phys == PW'(exp_p), "R1 reset map", lk_phys, exp_p);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle(); ren_valid = 1'b1; ren_arch = 5'd9;
      #5;
      chk(ren_phys == PW'(24 + k), "R3 fp pool order", ren_phys, 24 + k);
    end
    @(negedge clk);
    idle();
    #5;
    chk(free_count == 4'd5, "R8 min is fp pool", free_count, 5);

    finish_run();
  end
endmodule